// File: doc/BRIEF.md
# Rewindable Nine-Bit Queue with Half-Level Flag

This block is a single-clock first-in, first-out buffer for nine-bit words, enough for a byte plus one parity or framing bit. The producer and the consumer each drive a level request. A transfer takes place once for every assertion of a request, so one word moves per strobe however long the request stays high. Status goes out on three active-low flags: empty, full and more-than-half-full. A master reset returns the block to an empty state.

A rewind input sends the read pointer back to location zero and leaves the write pointer where it is. The words written since reset can then be read out a second time. Because a request that cannot be served stays pending while it is held, the block also gives two flow-through modes. A read held against an empty queue takes the next written word straight to the output. A write held against a full queue stores its word as soon as a read frees a slot. Read data is held in a register and is qualified by an output-valid signal rather than by a high-impedance state.

Top module: `rtx_fifo`

## Requirements
- R1: Words come out in the order they were written, with all nine bits unchanged.
- R2: While reset is low and after it is released: `empty_n`=0, `full_n`=1, `half_n`=1 and `rd_valid`=0.
- R3: A write strobe asserted and released while the queue is full stores nothing, and the occupancy is unchanged.
- R4: A read strobe asserted and released while the queue is empty returns nothing (`rd_valid` stays 0) and leaves the read pointer unchanged.
- R5: `full_n` is 0 exactly when the accepted writes exceed the accepted reads by DEPTH.
- R6: `empty_n` is 0 exactly when no word is stored. After the last word is popped, `empty_n` goes to 0 one cycle after the read, while `rd_data` keeps that word and `rd_valid` stays 1 until `rd_req` is released.
- R7: `half_n` is 0 exactly when more than DEPTH/2 words are stored. It rises only after a read or a rewind.
- R8: One assertion of a request performs at most one transfer, however long the request is held.
- R9: A rewind pulse while neither request is high sets the read pointer to zero and keeps the write pointer. The flags are recomputed by the next cycle (still full if DEPTH words were written without a read). A rewind while a request is high is ignored.
- R10: Automatic read: with a read held against an empty queue, a write raises `empty_n` for one cycle, and the next cycle delivers that word with `rd_valid`=1 and `empty_n` back at 0.
- R11: Automatic write: with a write held against a full queue, a read raises `full_n` for one cycle and the held word is then stored, with `full_n` back at 0.
- R12: A read and a write that take place in the same cycle leave the occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous master reset, active low |
| wr_req | input | 1 | Write request; one word is stored per assertion |
| wr_data | input | 9 | Word to store, sampled in the cycle the write takes place |
| rd_req | input | 1 | Read request; one word is popped per assertion |
| rewind | input | 1 | Returns the read pointer to location zero when both requests are low |
| rd_data | output | 9 | Last popped word, held until the next read |
| rd_valid | output | 1 | High from the cycle after a read until `rd_req` falls |
| empty_n | output | 1 | Low when no word is stored |
| full_n | output | 1 | Low when DEPTH words are stored |
| half_n | output | 1 | Low when more than DEPTH/2 words are stored |

## Verification
The bench runs a depth-eight instance through every fill level, both up and down, and compares the three flags with the expected occupancy at each step. A wrong comparison point shows up as a flag that is off by one word, or as a half flag that releases one read early. Strobes are held for several cycles to catch a design that pops on every cycle rather than once per assertion. Writes against a full queue and reads against an empty one are released before any slot or word appears, so a design that leaks them would hand out a phantom word or lose order. Rewind is tried with the queue idle, with a request high, and after the write pointer has wrapped. The two flow-through modes are timed cycle by cycle, so a design that serves a held request late, early, or not at all fails on the one-cycle flag pulse.

// File: rtl/rtx_fifo_pkg.sv
package rtx_fifo_pkg;
   localparam int WORD_W = 9;
   typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/rtx_fifo_strobe.sv
// Turns a level request into a single transfer per assertion. The request
// stays pending while held until the controller fires it.
module rtx_fifo_strobe (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   input  logic fire,
   output logic pending
);
   logic served_q;

   assign pending = req && !served_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) served_q <= 1'b0;
      else        served_q <= req && (served_q || fire);
   end

   // R8: once a transfer has fired, a continuously held request does not fire again
   assert_single_fire_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fire ##1 req |-> !fire);
endmodule

// File: rtl/rtx_fifo_mem.sv
module rtx_fifo_mem #(
   parameter int WIDTH = 9,
   parameter int DEPTH = 2048,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic             re,
   input  logic [AW-1:0]    raddr,
   output logic [WIDTH-1:0] rdata
);
   logic [WIDTH-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (we) store[waddr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  rdata <= '0;
      else if (re) rdata <= store[raddr];
   end
endmodule

// File: rtl/rtx_fifo_ctrl.sv
module rtx_fifo_ctrl #(
   parameter int DEPTH = 2048,
   localparam int AW = $clog2(DEPTH),
   localparam int CW = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_req,
   input  logic          rd_req,
   input  logic          wr_pend,
   input  logic          rd_pend,
   input  logic          rewind,
   output logic          wr_fire,
   output logic          rd_fire,
   output logic [AW-1:0] wr_ptr,
   output logic [AW-1:0] rd_ptr,
   output logic          empty_n,
   output logic          full_n,
   output logic          half_n
);
   localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
   localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);
   localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

   logic [CW-1:0] count;
   logic          wrapped;
   logic          is_empty, is_full, rewind_ok;

   assign is_empty  = (count == '0);
   assign is_full   = (count == FULL_CNT);
   assign wr_fire   = wr_pend && !is_full;
   assign rd_fire   = rd_pend && !is_empty;
   assign rewind_ok = rewind && !wr_req && !rd_req;

   assign empty_n = !is_empty;
   assign full_n  = !is_full;
   assign half_n  = !(count > HALF_CNT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr  <= '0;
         rd_ptr  <= '0;
         count   <= '0;
         wrapped <= 1'b0;
      end else if (rewind_ok) begin
         rd_ptr <= '0;
         count  <= wrapped ? FULL_CNT : {1'b0, wr_ptr};
      end else begin
         if (wr_fire) begin
            wr_ptr <= wr_ptr + AW'(1);
            if (wr_ptr == LAST_PTR) wrapped <= 1'b1;
         end
         if (rd_fire) rd_ptr <= rd_ptr + AW'(1);
         case ({wr_fire, rd_fire})
            2'b10:   count <= count + CW'(1);
            2'b01:   count <= count - CW'(1);
            default: count <= count;
         endcase
      end
   end

   // R3: with the queue full and no read, the write pointer does not move
   assert_full_blocks_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!full_n && !rd_pend) |=> $stable(wr_ptr));
   // R4: with the queue empty and no rewind, the read pointer does not move
   assert_empty_holds_rdptr_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!empty_n && !rewind_ok) |=> $stable(rd_ptr));
   // R5: occupancy never goes past the depth
   assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      count <= FULL_CNT);
   // R7: the half flag is released only by a read or a rewind
   assert_half_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(half_n) |-> ($past(rd_fire) || $past(rewind_ok)));
   // R9: a rewind zeroes the read pointer and keeps the write pointer
   assert_rewind_ptrs_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rewind_ok |=> (rd_ptr == '0) && $stable(wr_ptr));
   // R12: a read and a write in the same cycle keep the occupancy
   assert_paired_count_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_fire && rd_fire) |=> $stable(count));
endmodule

// File: rtl/rtx_fifo.sv
module rtx_fifo
   import rtx_fifo_pkg::*;
#(
   parameter int DEPTH = 2048,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  wr_req,
   input  word_t wr_data,
   input  logic  rd_req,
   input  logic  rewind,
   output word_t rd_data,
   output logic  rd_valid,
   output logic  empty_n,
   output logic  full_n,
   output logic  half_n
);
   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_depth_check
      $error("rtx_fifo: DEPTH must be a power of two and at least 4");
   end

   logic          wr_pend, rd_pend, wr_fire, rd_fire;
   logic [AW-1:0] wr_ptr, rd_ptr;

   rtx_fifo_strobe u_wr_strobe (
      .clk(clk), .rst_n(rst_n), .req(wr_req), .fire(wr_fire), .pending(wr_pend));

   rtx_fifo_strobe u_rd_strobe (
      .clk(clk), .rst_n(rst_n), .req(rd_req), .fire(rd_fire), .pending(rd_pend));

   rtx_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .wr_req(wr_req), .rd_req(rd_req),
      .wr_pend(wr_pend), .rd_pend(rd_pend), .rewind(rewind),
      .wr_fire(wr_fire), .rd_fire(rd_fire),
      .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
      .empty_n(empty_n), .full_n(full_n), .half_n(half_n));

   rtx_fifo_mem #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_mem (
      .clk(clk), .rst_n(rst_n),
      .we(wr_fire), .waddr(wr_ptr), .wdata(wr_data),
      .re(rd_fire), .raddr(rd_ptr), .rdata(rd_data));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_valid <= 1'b0;
      else        rd_valid <= rd_req && (rd_valid || rd_fire);
   end

   // R6: a popped word stays on the output while the read is held
   assert_word_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && rd_req) |=> $stable(rd_data));
   // R2: the output is not flagged valid without an active read request
   assert_valid_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(rd_req));
endmodule

// File: tb/rtx_fifo_tb_top.sv
module rtx_fifo_tb_top;
   import rtx_fifo_pkg::*;

   localparam int D = 8;

   logic  clk = 1'b0;
   logic  rst_n = 1'b0;
   logic  wr_req = 1'b0, rd_req = 1'b0, rewind = 1'b0;
   word_t wr_data = '0;
   word_t rd_data;
   logic  rd_valid, empty_n, full_n, half_n;

   int    nchk = 0, nerr = 0, exp_cnt = 0;
   bit    finished = 1'b0;
   word_t q[$];
   word_t hist[$];

   always #4 clk = ~clk;

   rtx_fifo #(.DEPTH(D)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_data(wr_data),
      .rd_req(rd_req), .rewind(rewind), .rd_data(rd_data), .rd_valid(rd_valid),
      .empty_n(empty_n), .full_n(full_n), .half_n(half_n));

   task automatic chk(string tag, int act, int exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic flags(string tag);
      chk({tag, " empty_n"}, int'(empty_n), int'(exp_cnt != 0));
      chk({tag, " full_n"},  int'(full_n),  int'(exp_cnt != D));
      chk({tag, " half_n"},  int'(half_n),  int'(!(exp_cnt > D / 2)));
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; wr_req = 1'b0; rd_req = 1'b0; rewind = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      q.delete(); hist.delete(); exp_cnt = 0;
   endtask

   task automatic push(word_t d);
      @(negedge clk);
      wr_req = 1'b1; wr_data = d;
      @(negedge clk);
      wr_req = 1'b0;
      if (exp_cnt < D) begin
         q.push_back(d); hist.push_back(d); exp_cnt++;
      end
   endtask

   task automatic pop(string tag);
      @(negedge clk);
      rd_req = 1'b1;
      @(negedge clk);
      chk({tag, " rd_valid"}, int'(rd_valid), 1);
      chk({tag, " rd_data"}, int'(rd_data), int'(q[0]));
      void'(q.pop_front());
      exp_cnt--;
      flags(tag);
      rd_req = 1'b0;
      @(negedge clk);
      chk({tag, " rd_valid release"}, int'(rd_valid), 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         nerr++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
         $finish;
      end
   end

   initial begin
      // R2: reset state
      @(negedge clk);
      chk("R2 in reset rd_valid", int'(rd_valid), 0);
      flags("R2 in reset");
      do_reset();
      @(negedge clk);
      chk("R2 after reset rd_valid", int'(rd_valid), 0);
      flags("R2 after reset");

      // R5, R7: sweep every fill level
      for (int i = 0; i < D; i++) begin
         push(word_t'(i * 53 + 7));
         flags("R5_R7 fill");
      end
      // R3: write into a full queue is dropped
      push(9'h1AA);
      flags("R3 full write");
      // R1, R6, R7: drain in order; last pop leaves word valid while empty
      for (int i = 0; i < D; i++) pop("R1_R6 drain");

      // R4: read against an empty queue, released before any write
      @(negedge clk); rd_req = 1'b1;
      repeat (2) @(negedge clk);
      chk("R4 empty read rd_valid", int'(rd_valid), 0);
      rd_req = 1'b0;
      @(negedge clk);
      flags("R4 empty read");
      push(9'h055);
      pop("R4 after empty read");

      // R8: a held read strobe pops exactly one word
      push(9'h101); push(9'h102); push(9'h103);
      @(negedge clk); rd_req = 1'b1;
      repeat (5) @(negedge clk);
      chk("R8 held read data", int'(rd_data), int'(q[0]));
      void'(q.pop_front()); exp_cnt--;
      flags("R8 held read");
      rd_req = 1'b0;
      pop("R8 next"); pop("R8 next");

      // R12: simultaneous read and write
      push(9'h0A1); push(9'h0A2); push(9'h0A3);
      @(negedge clk);
      wr_req = 1'b1; rd_req = 1'b1; wr_data = 9'h1F0;
      @(negedge clk);
      chk("R12 paired rd_data", int'(rd_data), int'(q[0]));
      void'(q.pop_front()); q.push_back(9'h1F0);
      flags("R12 paired");
      wr_req = 1'b0; rd_req = 1'b0;
      for (int i = 0; i < 3; i++) pop("R12 order");

      // R9: rewind replays from location zero
      do_reset();
      for (int i = 0; i < 5; i++) push(word_t'(9'h180 + i));
      for (int i = 0; i < 3; i++) pop("R9 first pass");
      @(negedge clk); rewind = 1'b1;
      @(negedge clk); rewind = 1'b0;
      q = hist; exp_cnt = 5;
      flags("R9 rewound");
      for (int i = 0; i < 5; i++) pop("R9 replay");
      // R9: rewind with a request high is ignored
      @(negedge clk); rd_req = 1'b1;
      @(negedge clk); rewind = 1'b1;
      @(negedge clk); rewind = 1'b0;
      @(negedge clk); rd_req = 1'b0;
      @(negedge clk);
      flags("R9 blocked rewind");
      // R9: rewind after a full wrap keeps full
      do_reset();
      for (int i = 0; i < D; i++) push(word_t'(i + 9'h020));
      @(negedge clk); rewind = 1'b1;
      @(negedge clk); rewind = 1'b0;
      @(negedge clk);
      flags("R9 wrapped rewind");

      // R10: automatic read
      do_reset();
      @(negedge clk); rd_req = 1'b1;
      repeat (3) @(negedge clk);
      chk("R10 waiting rd_valid", int'(rd_valid), 0);
      chk("R10 waiting empty_n", int'(empty_n), 0);
      wr_req = 1'b1; wr_data = 9'h0E7;
      @(negedge clk);
      wr_req = 1'b0;
      chk("R10 brief empty_n", int'(empty_n), 1);
      chk("R10 brief rd_valid", int'(rd_valid), 0);
      @(negedge clk);
      chk("R10 delivered empty_n", int'(empty_n), 0);
      chk("R10 delivered rd_valid", int'(rd_valid), 1);
      chk("R10 delivered rd_data", int'(rd_data), 9'h0E7);
      rd_req = 1'b0;
      @(negedge clk);

      // R11: automatic write
      do_reset();
      for (int i = 0; i < D; i++) push(word_t'(9'h140 + i));
      @(negedge clk); wr_req = 1'b1; wr_data = 9'h1C3;
      repeat (2) @(negedge clk);
      chk("R11 held full_n", int'(full_n), 0);
      rd_req = 1'b1;
      @(negedge clk);
      chk("R11 slot full_n", int'(full_n), 1);
      chk("R11 slot rd_data", int'(rd_data), int'(q[0]));
      rd_req = 1'b0;
      @(negedge clk);
      chk("R11 stored full_n", int'(full_n), 0);
      wr_req = 1'b0;
      void'(q.pop_front()); q.push_back(9'h1C3);
      @(negedge clk);
      for (int i = 0; i < D; i++) pop("R11 drain order");

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end
endmodule